// File: doc/BRIEF.md
# Interrupt-on-Change Controller

This block watches two 8-bit input ports and raises an interrupt when an enabled input pin changes. Each pin can be watched in one of two ways: against the level it had on the previous clock, which catches any toggle, or against a programmed default bit, which catches a mismatch. The pins are brought into the clock domain through a two-stage synchronizer first. The first qualifying event on a port records which pins caused it in a read-only flag register and stores the whole synchronized port value in a capture register. After that, the port ignores further events until the bus side strobes a read of that port's capture or port register.

Each port has its own interrupt output. The output can be driven push-pull with either active level, or as an open-drain style signal where a separate output-enable marks when the line is pulled low. A mirror setting makes both outputs show the OR of the two ports' interrupts, so a system with only one interrupt line can still serve both ports.

Top module: `ioc_irq_ctrl`

## Requirements
- R1: A pin raises an event only when its direction bit is 1 (input) and its enable bit is 1. When several pins qualify on the same cycle, all of their flag bits are set together.
- R2: In change mode (compare bit 0), a toggle on a qualifying pin sets that pin's flag bit three clock edges after the pin moves. On that same edge the capture register takes the whole synchronized port value.
- R3: In default-compare mode (compare bit 1), a pin whose synchronized level differs from its default bit raises an event. A pin that matches its default bit raises none.
- R4: While any flag bit of a port is set, further events on that port leave both its flag and its capture register unchanged.
- R5: A one-cycle strobe on the capture-read or the port-read input of a port clears all of that port's flag bits on that edge. The capture register keeps its value.
- R6: After a clear, a pin in default-compare mode that still mismatches raises its flag again on the next edge. A pin in change mode does not raise it again unless it moves again.
- R7: With mirror at 0, each interrupt output follows only its own port. With mirror at 1, both outputs follow the OR of the two ports' pending states.
- R8: With open-drain off, the output-enable is 1. The output equals the pending state when the polarity bit is 1, and its inverse when the polarity bit is 0.
- R9: With open-drain on, the output value is 0 and the output-enable equals the pending state, whatever the polarity bit.
- R10: During reset, flags, captures, synchronized port values, interrupt outputs and output-enables are all 0.
- R11: The port value output shows the pin levels two clock edges after they are applied.
- R12: An interrupt output reflects a change in pending state or configuration one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 8 | Raw pin levels, port A |
| pin_b | input | 8 | Raw pin levels, port B |
| dir_a | input | 8 | Direction, port A (1 = input) |
| dir_b | input | 8 | Direction, port B (1 = input) |
| en_a | input | 8 | Per-pin interrupt enable, port A |
| en_b | input | 8 | Per-pin interrupt enable, port B |
| cmp_a | input | 8 | Compare mode, port A (1 = against default, 0 = against previous) |
| cmp_b | input | 8 | Compare mode, port B |
| def_a | input | 8 | Default levels, port A |
| def_b | input | 8 | Default levels, port B |
| cfg_mirror | input | 1 | 1 = both outputs show the OR of both ports |
| cfg_odr | input | 1 | 1 = open-drain style output |
| cfg_pol | input | 1 | Push-pull active level (1 = high) |
| rd_cap_a | input | 1 | Capture register read strobe, port A |
| rd_port_a | input | 1 | Port register read strobe, port A |
| rd_cap_b | input | 1 | Capture register read strobe, port B |
| rd_port_b | input | 1 | Port register read strobe, port B |
| flag_a | output | 8 | Pins that caused the pending event, port A |
| flag_b | output | 8 | Pins that caused the pending event, port B |
| cap_a | output | 8 | Port A value captured at the event |
| cap_b | output | 8 | Port B value captured at the event |
| port_a | output | 8 | Synchronized port A value |
| port_b | output | 8 | Synchronized port B value |
| irq_a_o | output | 1 | Interrupt output A value |
| irq_a_oe | output | 1 | Interrupt output A enable |
| irq_b_o | output | 1 | Interrupt output B value |
| irq_b_oe | output | 1 | Interrupt output B enable |

## Verification
Change mode is tried by toggling each of the eight pins on both ports in turn from varied baselines. This shows that exactly one flag bit follows the moving pin and that the capture holds the full port value, not just that bit. A second toggle while the event is pending must leave both registers alone. Default-compare mode is swept with many default values and single- and multi-bit mismatches, to tell a level mismatch apart from a toggle and to show that the flag returns after a clear. Direction and enable masks are swept with every pin toggling at once, and all eight output configurations are tried against all four pending combinations of the two ports. This separates mirroring, polarity and open-drain drive from one another.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

  typedef struct packed {
    logic mirror;
    logic odr;
    logic pol;
  } ioc_cfg_t;

  typedef enum logic [1:0] {
    DRV_PUSH_HIGH = 2'd0,
    DRV_PUSH_LOW  = 2'd1,
    DRV_OPEN      = 2'd2
  } ioc_drive_e;

  function automatic ioc_drive_e drive_mode(input ioc_cfg_t c);
    if (c.odr)      return DRV_OPEN;
    else if (c.pol) return DRV_PUSH_HIGH;
    else            return DRV_PUSH_LOW;
  endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ioc_port_unit.sv
module ioc_port_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] en,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] def,
  input  logic         clr,
  output logic [W-1:0] flag,
  output logic [W-1:0] cap,
  output logic         pending
);

  logic [W-1:0] prev;
  logic [W-1:0] hit;

  // Per-pin detector: mismatch against default or against last sample
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic ref_bit;
    assign ref_bit = cmp[i] ? def[i] : prev[i];
    assign hit[i]  = dir[i] & en[i] & (cur[i] ^ ref_bit);
  end

  assign pending = |flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      flag <= '0;
      cap  <= '0;
    end else begin
      prev <= cur;
      if (clr) begin
        flag <= '0;
      end else if (!pending && (|hit)) begin
        flag <= hit;
        cap  <= cur;
      end
    end
  end

endmodule

// File: rtl/ioc_out_drive.sv
module ioc_out_drive
  import ioc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     active,
  input  ioc_cfg_t cfg,
  output logic     out,
  output logic     oe
);

  ioc_drive_e mode;
  assign mode = drive_mode(cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      out <= 1'b0;
      oe  <= 1'b0;
    end else begin
      unique case (mode)
        DRV_OPEN:      begin out <= 1'b0;    oe <= active; end
        DRV_PUSH_HIGH: begin out <= active;  oe <= 1'b1;   end
        default:       begin out <= ~active; oe <= 1'b1;   end
      endcase
    end
  end

endmodule

// File: rtl/ioc_irq_ctrl.sv
module ioc_irq_ctrl
  import ioc_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_a,
  input  logic [W-1:0] pin_b,
  input  logic [W-1:0] dir_a,
  input  logic [W-1:0] dir_b,
  input  logic [W-1:0] en_a,
  input  logic [W-1:0] en_b,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [W-1:0] def_a,
  input  logic [W-1:0] def_b,
  input  logic         cfg_mirror,
  input  logic         cfg_odr,
  input  logic         cfg_pol,
  input  logic         rd_cap_a,
  input  logic         rd_port_a,
  input  logic         rd_cap_b,
  input  logic         rd_port_b,
  output logic [W-1:0] flag_a,
  output logic [W-1:0] flag_b,
  output logic [W-1:0] cap_a,
  output logic [W-1:0] cap_b,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         irq_a_o,
  output logic         irq_a_oe,
  output logic         irq_b_o,
  output logic         irq_b_oe
);

  localparam int NP = 2;

  logic [NP-1:0][W-1:0] pin_v, dir_v, en_v, cmp_v, def_v;
  logic [NP-1:0][W-1:0] cur_v, flag_v, cap_v;
  logic [NP-1:0]        clr_v, pend_v, raw_v, out_v, oe_v;
  logic                 any_pend;
  ioc_cfg_t             cfg;

  assign pin_v = {pin_b, pin_a};
  assign dir_v = {dir_b, dir_a};
  assign en_v  = {en_b,  en_a};
  assign cmp_v = {cmp_b, cmp_a};
  assign def_v = {def_b, def_a};
  assign clr_v = {rd_cap_b | rd_port_b, rd_cap_a | rd_port_a};

  assign cfg.mirror = cfg_mirror;
  assign cfg.odr    = cfg_odr;
  assign cfg.pol    = cfg_pol;

  assign any_pend = |pend_v;

  for (genvar p = 0; p < NP; p++) begin : g_port
    ioc_sync #(.W(W), .STAGES(STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_v[p]),
      .q   (cur_v[p])
    );

    ioc_port_unit #(.W(W)) u_unit (
      .clk     (clk),
      .rst     (rst),
      .cur     (cur_v[p]),
      .dir     (dir_v[p]),
      .en      (en_v[p]),
      .cmp     (cmp_v[p]),
      .def     (def_v[p]),
      .clr     (clr_v[p]),
      .flag    (flag_v[p]),
      .cap     (cap_v[p]),
      .pending (pend_v[p])
    );

    assign raw_v[p] = cfg.mirror ? any_pend : pend_v[p];

    ioc_out_drive u_drv (
      .clk    (clk),
      .rst    (rst),
      .active (raw_v[p]),
      .cfg    (cfg),
      .out    (out_v[p]),
      .oe     (oe_v[p])
    );
  end

  assign flag_a   = flag_v[0];
  assign flag_b   = flag_v[1];
  assign cap_a    = cap_v[0];
  assign cap_b    = cap_v[1];
  assign port_a   = cur_v[0];
  assign port_b   = cur_v[1];
  assign irq_a_o  = out_v[0];
  assign irq_a_oe = oe_v[0];
  assign irq_b_o  = out_v[1];
  assign irq_b_oe = oe_v[1];

endmodule

// File: rtl/ioc_irq_ctrl_chk.sv
module ioc_irq_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] dir_a,
  input logic [W-1:0] en_a,
  input logic         cfg_mirror,
  input logic         cfg_odr,
  input logic         rd_cap_a,
  input logic         rd_port_a,
  input logic [W-1:0] flag_a,
  input logic [W-1:0] cap_a,
  input logic [W-1:0] port_a,
  input logic         irq_a_o,
  input logic         irq_a_oe,
  input logic         irq_b_o,
  input logic         irq_b_oe
);

  p_masked_r1: assert property (@(posedge clk) disable iff (rst)
    ((flag_a & ~$past(flag_a)) != '0) |->
      ((flag_a & ~($past(dir_a) & $past(en_a))) == '0));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (($past(flag_a) == '0) && (flag_a != '0)) |-> (cap_a == $past(port_a)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((flag_a != '0) && !rd_cap_a && !rd_port_a) |=> ($stable(flag_a) && $stable(cap_a)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_cap_a || rd_port_a) |=> (flag_a == '0));

  p_mirror_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mirror && !cfg_odr) |=> ((irq_a_o == irq_b_o) && (irq_a_oe == irq_b_oe)));

  p_open_drain_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_odr |=> (!irq_a_o && !irq_b_o));

  p_push_pull_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_odr |=> (irq_a_oe && irq_b_oe));

endmodule

bind ioc_irq_ctrl ioc_irq_ctrl_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dir_a      (dir_a),
  .en_a       (en_a),
  .cfg_mirror (cfg_mirror),
  .cfg_odr    (cfg_odr),
  .rd_cap_a   (rd_cap_a),
  .rd_port_a  (rd_port_a),
  .flag_a     (flag_a),
  .cap_a      (cap_a),
  .port_a     (port_a),
  .irq_a_o    (irq_a_o),
  .irq_a_oe   (irq_a_oe),
  .irq_b_o    (irq_b_o),
  .irq_b_oe   (irq_b_oe)
);

// File: tb/ioc_irq_ctrl_test.sv
`timescale 1ns/1ps
module ioc_irq_ctrl_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pins [2];
  logic [7:0] dir  [2];
  logic [7:0] en   [2];
  logic [7:0] cmp  [2];
  logic [7:0] def  [2];
  logic       rdc  [2];
  logic       rdp  [2];
  logic cfg_mirror, cfg_odr, cfg_pol;

  logic [7:0] flag_a, flag_b, cap_a, cap_b, port_a, port_b;
  logic irq_a_o, irq_a_oe, irq_b_o, irq_b_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ioc_irq_ctrl uut (
    .clk(clk), .rst(rst),
    .pin_a(pins[0]), .pin_b(pins[1]),
    .dir_a(dir[0]), .dir_b(dir[1]),
    .en_a(en[0]), .en_b(en[1]),
    .cmp_a(cmp[0]), .cmp_b(cmp[1]),
    .def_a(def[0]), .def_b(def[1]),
    .cfg_mirror(cfg_mirror), .cfg_odr(cfg_odr), .cfg_pol(cfg_pol),
    .rd_cap_a(rdc[0]), .rd_port_a(rdp[0]),
    .rd_cap_b(rdc[1]), .rd_port_b(rdp[1]),
    .flag_a(flag_a), .flag_b(flag_b), .cap_a(cap_a), .cap_b(cap_b),
    .port_a(port_a), .port_b(port_b),
    .irq_a_o(irq_a_o), .irq_a_oe(irq_a_oe),
    .irq_b_o(irq_b_o), .irq_b_oe(irq_b_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] flg(input int p);
    return (p == 0) ? flag_a : flag_b;
  endfunction
  function automatic logic [7:0] cpt(input int p);
    return (p == 0) ? cap_a : cap_b;
  endfunction
  function automatic logic [7:0] prt(input int p);
    return (p == 0) ? port_a : port_b;
  endfunction
  function automatic logic irqo(input int p);
    return (p == 0) ? irq_a_o : irq_b_o;
  endfunction

  task automatic clear_port(input int p, input bit use_cap);
    if (use_cap) rdc[p] = 1'b1; else rdp[p] = 1'b1;
    tick(1);
    rdc[p] = 1'b0;
    rdp[p] = 1'b0;
  endtask

  task automatic settle(input int p);
    tick(4);
    clear_port(p, 1'b0);
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      pins[p] = 8'h00; dir[p] = 8'hFF; en[p] = 8'hFF;
      cmp[p] = 8'h00; def[p] = 8'h00; rdc[p] = 1'b0; rdp[p] = 1'b0;
    end
    cfg_mirror = 1'b0; cfg_odr = 1'b0; cfg_pol = 1'b1;
    pins[0] = 8'h5A;
    tick(3);
    // R10: reset state
    chk("R10 flag_a", {24'b0, flag_a}, 0);
    chk("R10 cap_a",  {24'b0, cap_a}, 0);
    chk("R10 port_a", {24'b0, port_a}, 0);
    chk("R10 irq oe", {30'b0, irq_a_oe, irq_b_oe}, 0);
    chk("R10 irq o",  {30'b0, irq_a_o, irq_b_o}, 0);
    rst = 1'b0;
    pins[0] = 8'h00;
    tick(2);
    chk("R8 idle push-pull", {30'b0, irq_a_o, irq_a_oe}, 32'h1);

    // R2, R4, R5, R6 (change mode), R11, R12: walk each pin of each port
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] base, nv;
        base = 8'(i * 29 + p * 7);
        pins[p] = base;
        settle(p);
        nv = base ^ (8'h01 << i);
        pins[p] = nv;
        tick(1);
        chk("R11 port after one edge", {24'b0, prt(p)}, {24'b0, base});
        tick(1);
        chk("R11 port after two edges", {24'b0, prt(p)}, {24'b0, nv});
        tick(1);
        chk("R2 flag", {24'b0, flg(p)}, {24'b0, 8'h01 << i});
        chk("R2 capture", {24'b0, cpt(p)}, {24'b0, nv});
        chk("R12 irq before edge", {31'b0, irqo(p)}, 0);
        tick(1);
        chk("R12 irq asserted", {31'b0, irqo(p)}, 1);
        pins[p] = nv ^ (8'h01 << ((i + 3) % 8));
        tick(4);
        chk("R4 flag held", {24'b0, flg(p)}, {24'b0, 8'h01 << i});
        chk("R4 capture held", {24'b0, cpt(p)}, {24'b0, nv});
        clear_port(p, i[0]);
        chk("R5 flag cleared", {24'b0, flg(p)}, 0);
        chk("R5 capture kept", {24'b0, cpt(p)}, {24'b0, nv});
        tick(3);
        chk("R6 change mode no re-raise", {24'b0, flg(p)}, 0);
        chk("R12 irq released", {31'b0, irqo(p)}, 0);
      end
    end

    // R1: direction and enable mask sweep, all pins toggle at once
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] dm, em, b;
        dm = 8'(k * 37 + 3);
        em = 8'(k * 91 + 5);
        b  = 8'(k * 13);
        dir[p] = 8'hFF; en[p] = 8'hFF;
        pins[p] = b;
        settle(p);
        dir[p] = dm; en[p] = em;
        pins[p] = ~b;
        tick(3);
        chk("R1 masked flag", {24'b0, flg(p)}, {24'b0, dm & em});
        tick(1);
        chk("R1 masked irq", {31'b0, irqo(p)}, {31'b0, |(dm & em)});
        clear_port(p, 1'b1);
        dir[p] = 8'hFF; en[p] = 8'hFF;
      end
    end

    // R3, R6: default-compare mode sweep
    for (int p = 0; p < 2; p++) begin
      cmp[p] = 8'hFF;
      for (int k = 0; k < 16; k++) begin
        logic [7:0] d, x;
        d = 8'(k * 53 + 1);
        x = 8'(k * 11 + 1);
        pins[p] = d; def[p] = d;
        tick(4);
        clear_port(p, 1'b0);
        tick(1);
        chk("R3 match raises nothing", {24'b0, flg(p)}, 0);
        pins[p] = d ^ x;
        tick(3);
        chk("R3 mismatch flag", {24'b0, flg(p)}, {24'b0, x});
        chk("R3 capture", {24'b0, cpt(p)}, {24'b0, d ^ x});
        clear_port(p, k[0]);
        chk("R5 compare clear", {24'b0, flg(p)}, 0);
        tick(1);
        chk("R6 compare re-raise", {24'b0, flg(p)}, {24'b0, x});
        pins[p] = d;
        tick(3);
        clear_port(p, 1'b1);
        tick(2);
        chk("R6 compare quiet after match", {24'b0, flg(p)}, 0);
      end
      cmp[p] = 8'h00;
      def[p] = 8'h00;
      pins[p] = 8'h00;
      settle(p);
    end

    // R7, R8, R9: output configuration against pending combinations
    for (int s = 0; s < 4; s++) begin
      logic ia, ib;
      ia = s[0]; ib = s[1];
      settle(0);
      settle(1);
      if (ia) pins[0] = pins[0] ^ 8'h01;
      if (ib) pins[1] = pins[1] ^ 8'h80;
      tick(4);
      for (int c = 0; c < 8; c++) begin
        logic ra, rb, eo_a, eo_b, ee_a, ee_b;
        string tag;
        cfg_mirror = c[2]; cfg_odr = c[1]; cfg_pol = c[0];
        tick(2);
        ra = cfg_mirror ? (ia | ib) : ia;
        rb = cfg_mirror ? (ia | ib) : ib;
        eo_a = cfg_odr ? 1'b0 : (cfg_pol ? ra : ~ra);
        eo_b = cfg_odr ? 1'b0 : (cfg_pol ? rb : ~rb);
        ee_a = cfg_odr ? ra : 1'b1;
        ee_b = cfg_odr ? rb : 1'b1;
        tag = cfg_odr ? "R9 open drain" : (cfg_mirror ? "R7 mirror" : "R8 polarity");
        chk({tag, " out a/b"}, {30'b0, irq_a_o, irq_b_o}, {30'b0, eo_a, eo_b});
        chk({tag, " oe a/b"}, {30'b0, irq_a_oe, irq_b_oe}, {30'b0, ee_a, ee_b});
      end
      cfg_mirror = 1'b0; cfg_odr = 1'b0; cfg_pol = 1'b1;
      tick(2);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule